// File: doc/BRIEF.md
# Priority Prefetch Queue with Duplicate Filtering

This block holds pending prefetch targets until the memory side can accept them. Each slot keeps an address, a signed priority and the cycle from which it may leave. The slots are kept sorted, with the highest priority at the head. Entries of equal priority leave in the order they arrived. Each cycle the block accepts at most one insert and issues at most one head entry, through a valid/ready handshake.

When an insert names an address that is already queued, no slot is added. If the new priority is strictly higher, the queued entry takes it and moves forward. When every slot is taken, the block drops the oldest entry of the lowest priority level to make room. A separate lookup port lets a neighbouring queue ask whether an address is already held here. Three running counters record filtered inserts, evictions and issues.

Top module: `prio_pf_queue`

## Requirements
- R1: After reset the queue is empty, `iss_valid` and `lk_hit` are low, and all three counters read zero.
- R2: Entries issue in descending signed priority order, and equal priorities issue in arrival order.
- R3: An entry is never presented on `iss_*` before LAT clock edges have elapsed. The count includes the edge that accepted the insert. The entry is presented at that point if it is at the head.
- R4: When an insert needs a free slot and all DEPTH slots are in use, the oldest entry among those holding the lowest priority is dropped. In the same cycle `evict_cnt` increments by one.
- R5: An insert whose address is already queued adds no entry, and `hit_cnt` increments by one.
- R6: A duplicate insert with a strictly higher priority gives the queued entry that priority. The entry moves ahead of every entry with a lower priority and stays behind entries of equal or higher priority. A duplicate with an equal or lower priority changes nothing in the queue.
- R7: Each handshake where `iss_valid` and `iss_ready` are both high removes the head and increments `issue_cnt` by one.
- R8: `lk_hit` is high exactly when `lk_addr` equals the address of a queued entry.
- R9: An issue and an insert in the same cycle both take effect. The head leaves first, then the insert is applied to what remains.
- R10: Priority is a two's-complement signed value, so negative priorities rank below zero and below positive priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_addr | input | AW | Target address of the insert |
| ins_prio | input | PW | Signed priority of the insert |
| iss_valid | output | 1 | Head entry present and ready |
| iss_ready | input | 1 | Consumer takes the head |
| iss_addr | output | AW | Head address |
| iss_prio | output | PW | Head priority |
| lk_addr | input | AW | Address probed by a sibling queue |
| lk_hit | output | 1 | Probed address is queued |
| hit_cnt | output | CW | Filtered duplicate inserts |
| evict_cnt | output | CW | Entries dropped because the queue was full |
| issue_cnt | output | CW | Entries issued |

## Verification
The bench builds the queue with DEPTH=4, AW=8 and LAT=2. Four slots and eight addresses make overflow, duplicates and promotions frequent, so a long, deterministic sweep of insert bursts reaches all of them many times. Each burst is compared against a sorted reference list kept in the bench, and the full drain order and the counters are checked after every burst. With LAT=2 the head is hidden for one cycle after it is accepted, so that cycle can be checked. Same-cycle issue with insert and the lookup port are checked separately.

// File: rtl/prio_pf_queue.sv
module prio_pf_queue #(
  parameter int DEPTH  = 32,
  parameter int AW     = 32,
  parameter int PW     = 32,
  parameter int LAT    = 1,
  parameter int TW     = 32,
  parameter int CW     = 32,
  parameter bit FILTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [PW-1:0] ins_prio,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [AW-1:0] iss_addr,
  output logic [PW-1:0] iss_prio,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [CW-1:0] hit_cnt,
  output logic [CW-1:0] evict_cnt,
  output logic [CW-1:0] issue_cnt
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  typedef struct packed {
    logic [AW-1:0] a;
    logic [PW-1:0] p;
    logic [TW-1:0] t;
  } ent_t;

  ent_t q [DEPTH];
  ent_t s0 [DEPTH];
  ent_t s1 [DEPTH];
  ent_t s2 [DEPTH];
  logic [CNTW-1:0] cnt, c0, c1, c2;
  logic [TW-1:0] now;
  logic pop, dup, filt, promote, evict, do_rm, do_ins;
  ent_t dup_e, newe;
  logic [CNTW-1:0] dup_idx, ev_idx, rm_idx, pos;

  assign iss_valid = (cnt != '0) && ($signed(now - q[0].t) >= 0);
  assign iss_addr  = q[0].a;
  assign iss_prio  = q[0].p;
  assign pop       = iss_valid && iss_ready;

  always_comb begin
    lk_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CNTW'(i) < cnt && q[i].a == lk_addr) lk_hit = 1'b1;
  end

  always_comb begin
    s0 = q;
    c0 = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) s0[i] = q[i+1];
      s0[DEPTH-1] = '0;
      c0 = cnt - 1'b1;
    end

    dup = 1'b0;
    dup_idx = '0;
    dup_e = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!dup && CNTW'(i) < c0 && s0[i].a == ins_addr) begin
        dup = 1'b1;
        dup_idx = CNTW'(i);
        dup_e = s0[i];
      end

    ev_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (s0[i].p == s0[DEPTH-1].p) ev_idx = CNTW'(i);

    filt    = FILTER && dup;
    promote = ins_valid && filt && ($signed(ins_prio) > $signed(dup_e.p));
    evict   = ins_valid && !filt && (c0 == FULL);
    do_rm   = promote || evict;
    do_ins  = promote || (ins_valid && !filt);
    rm_idx  = promote ? dup_idx : ev_idx;

    s1 = s0;
    c1 = c0;
    if (do_rm) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (CNTW'(i) >= rm_idx) s1[i] = s0[i+1];
      s1[DEPTH-1] = '0;
      c1 = c0 - 1'b1;
    end

    pos = c1;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (CNTW'(i) < c1 && $signed(s1[i].p) < $signed(ins_prio)) pos = CNTW'(i);

    newe.a = ins_addr;
    newe.p = ins_prio;
    newe.t = promote ? dup_e.t : now + TW'(LAT);

    s2 = s1;
    c2 = c1;
    if (do_ins) begin
      if (pos == '0) s2[0] = newe;
      for (int i = 1; i < DEPTH; i++) begin
        if (CNTW'(i) == pos)     s2[i] = newe;
        else if (CNTW'(i) > pos) s2[i] = s1[i-1];
      end
      c2 = c1 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      cnt       <= '0;
      now       <= '0;
      hit_cnt   <= '0;
      evict_cnt <= '0;
      issue_cnt <= '0;
    end else begin
      q   <= s2;
      cnt <= c2;
      now <= now + 1'b1;
      if (ins_valid && filt) hit_cnt <= hit_cnt + 1'b1;
      if (evict)             evict_cnt <= evict_cnt + 1'b1;
      if (pop)               issue_cnt <= issue_cnt + 1'b1;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_evict_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_cnt != $past(evict_cnt)) |-> ($past(cnt) == FULL));

  assert_issue_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> (issue_cnt == $past(issue_cnt) + 1'b1));

  assert_hit_keeps_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt != $past(hit_cnt)) |-> (cnt <= $past(cnt)));

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_sorted
    assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (CNTW'(g + 1) < cnt) |-> ($signed(q[g].p) >= $signed(q[g+1].p)));
  end
endmodule

// File: tb/test_prio_pf_queue.sv
`timescale 1ns/1ps
module test_prio_pf_queue;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int PW = 32;
  localparam int LAT = 2;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [PW-1:0] ins_prio = '0;
  logic iss_valid, iss_ready, lk_hit;
  logic [AW-1:0] iss_addr, lk_addr;
  logic [PW-1:0] iss_prio;
  logic [CW-1:0] hit_cnt, evict_cnt, issue_cnt;

  int nchk = 0, nerr = 0;
  int ma[$];
  int mp[$];
  int m_hits = 0, m_evicts = 0, m_issues = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_pf_queue #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .LAT(LAT), .CW(CW)) i_prio_pf_queue (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_prio(ins_prio), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_addr(iss_addr), .iss_prio(iss_prio), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .hit_cnt(hit_cnt), .evict_cnt(evict_cnt), .issue_cnt(issue_cnt));

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_ins(int a, int p);
    int d, k;
    d = -1;
    foreach (ma[i]) if (d < 0 && ma[i] == a) d = i;
    if (d >= 0) begin
      m_hits++;
      if (p <= mp[d]) return;
      ma.delete(d);
      mp.delete(d);
    end else if (ma.size() == DEPTH) begin
      k = -1;
      foreach (mp[i]) if (k < 0 && mp[i] == mp[DEPTH-1]) k = i;
      ma.delete(k);
      mp.delete(k);
      m_evicts++;
    end
    k = ma.size();
    for (int i = ma.size() - 1; i >= 0; i--) if (mp[i] < p) k = i;
    ma.insert(k, a);
    mp.insert(k, p);
  endfunction

  task automatic ins(int a, int p);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_addr = AW'(a);
    ins_prio = PW'(p);
    @(posedge clk);
    #1 ins_valid = 1'b0;
    model_ins(a, p);
  endtask

  task automatic drain(string tag);
    while (ma.size() > 0) begin
      int w = 0;
      @(negedge clk);
      while (!iss_valid && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk(iss_valid == 1'b1, {"R3 head valid ", tag}, int'(iss_valid), 1);
      chk(int'(iss_addr) == ma[0], {"R2 issue addr ", tag}, int'(iss_addr), ma[0]);
      chk($signed(iss_prio) == mp[0], {"R10 issue prio ", tag}, $signed(iss_prio), mp[0]);
      iss_ready = 1'b1;
      @(posedge clk);
      #1 iss_ready = 1'b0;
      ma.delete(0);
      mp.delete(0);
      m_issues++;
    end
    repeat (LAT + 1) @(negedge clk);
    chk(iss_valid == 1'b0, {"R2 empty after drain ", tag}, int'(iss_valid), 0);
    chk(int'(issue_cnt) == m_issues, "R7 issue_cnt", int'(issue_cnt), m_issues);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    iss_ready = 1'b0;
    lk_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(iss_valid == 1'b0, "R1 iss_valid", int'(iss_valid), 0);
    chk(lk_hit == 1'b0, "R1 lk_hit", int'(lk_hit), 0);
    chk(hit_cnt == 0 && evict_cnt == 0 && issue_cnt == 0, "R1 counters",
        int'(hit_cnt + evict_cnt + issue_cnt), 0);

    // R3: LAT=2, hidden for the cycle after acceptance
    ins(5, 7);
    @(negedge clk);
    chk(iss_valid == 1'b0, "R3 not before LAT", int'(iss_valid), 0);
    @(negedge clk);
    chk(iss_valid == 1'b1, "R3 valid at LAT", int'(iss_valid), 1);

    // R8 lookup
    lk_addr = 8'd5;
    #1 chk(lk_hit == 1'b1, "R8 lookup hit", int'(lk_hit), 1);
    lk_addr = 8'd6;
    #1 chk(lk_hit == 1'b0, "R8 lookup miss", int'(lk_hit), 0);

    // R9 simultaneous issue and insert
    @(negedge clk);
    iss_ready = 1'b1;
    ins_valid = 1'b1;
    ins_addr = 8'd5;
    ins_prio = PW'(1);
    @(posedge clk);
    #1 begin
      iss_ready = 1'b0;
      ins_valid = 1'b0;
    end
    ma.delete(0);
    mp.delete(0);
    m_issues++;
    model_ins(5, 1);
    @(negedge clk);
    chk(int'(hit_cnt) == 0, "R9 same addr not filtered after pop", int'(hit_cnt), 0);
    chk(iss_valid == 1'b0, "R9 new head waits LAT", int'(iss_valid), 0);
    drain("R9");

    // R10 directed: negative below positive
    ins(1, -1);
    ins(2, 1);
    ins(3, 0);
    drain("R10");

    // R6 directed: equal-priority duplicate leaves order; higher promotes
    ins(1, 2);
    ins(2, 2);
    ins(3, 2);
    ins(3, 2);
    ins(2, 3);
    chk(int'(hit_cnt) == m_hits, "R5 hit_cnt directed", int'(hit_cnt), m_hits);
    drain("R6");

    // R4 directed: overflow drops oldest of lowest level
    ins(1, 0);
    ins(2, 0);
    ins(3, 5);
    ins(4, 5);
    ins(6, 9);
    chk(int'(evict_cnt) == m_evicts, "R4 evict_cnt directed", int'(evict_cnt), m_evicts);
    drain("R4");

    // sweep of insert bursts against the reference list
    for (int r = 0; r < 300; r++) begin
      for (int i = 0; i < 6; i++) begin
        int a, p;
        a = (r * 5 + i * 3 + (r >> 2)) % 8;
        p = ((r * 3 + i * 7 + (r >> 3)) % 7) - 3;
        ins(a, p);
      end
      @(negedge clk);
      chk(int'(hit_cnt) == m_hits, "R5 hit_cnt sweep", int'(hit_cnt), m_hits);
      chk(int'(evict_cnt) == m_evicts, "R4 evict_cnt sweep", int'(evict_cnt), m_evicts);
      drain("sweep R2 R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule